// File: doc/BRIEF.md
# CAN Bus-Off Recovery Controller

This block decides when a CAN protocol engine may leave the bus-off state and go back to traffic. It holds the controller mode. Host software asks for a mode change by pulsing a request together with a 3-bit mode code, and the block decides whether to accept, defer or reject it. The protocol engine reports bus-off entry with a single-cycle pulse. From then on the block keeps the transmit line recessive, whatever bit the engine presents.

Recovery starts in one of two ways. One is an operation-mode request made from initialization mode. The other is leaving sleep mode, either through a host request or through a dominant edge on the bus. Once recovery is under way, the block samples the received bit at every bit-time strobe and counts completed runs of 11 recessive bits on a 7-bit counter that software can read. It grants the deferred operation mode only after the 128th run.

Top module: `can_busoff_ctrl`

## Requirements
- R1: While `busoff_o` is 1, or the mode is not an operation mode, `tx_o` is 1 (recessive). Otherwise `tx_o` equals `tx_bit_i`.
- R2: Mode codes are 000 init, 001 normal, 010 listen, 011 self-test, 100 sleep and 101 stop; 001 to 011 are the operation modes. A `busoff_enter_i` pulse taken in an operation mode sets `busoff_o` in the next cycle. In any other mode the pulse is ignored.
- R3: A request with code 000, made from init or from an operation mode, shows `mode_o` = 000 in the next cycle.
- R4: An operation-mode request made in init while bus-off leaves `mode_o` at 000. The request is stored as pending, recovery starts and `run_cnt_o` is cleared.
- R5: During recovery, at each strobe a sampled 1 (recessive) extends the current run and a sampled 0 restarts it. The 11th consecutive recessive bit adds 1 to `run_cnt_o`, and the next run starts from zero, so runs never overlap.
- R6: At the strobe that completes the 128th run, the next cycle shows `busoff_o` = 0, `run_cnt_o` = 0 and `mode_o` equal to the pending mode.
- R7: A new operation-mode request during recovery clears `run_cnt_o` and replaces the pending mode. All 128 runs are then needed again.
- R8: `busoff_o` stays 1 from entry until recovery completes, including while in init, sleep and stop.
- R9: A sleep request is accepted from init or from an operation mode. A stop request is accepted only from sleep. A sleep request made in stop returns to sleep. An init request made in sleep or stop is ignored.
- R10: An operation-mode request made in sleep while bus-off gives `mode_o` = 000 in the next cycle and starts recovery at once, with the counter cleared. Without bus-off, the same request enters the requested mode directly.
- R11: A dominant edge in sleep with no request in that cycle leaves sleep. A dominant edge is a strobe that samples 0 when the previous strobe sampled 1. If bus-off, recovery starts toward the last requested operation mode (001 after reset). Otherwise that mode is entered directly.
- R12: Without bus-off, an operation-mode request from init takes effect in the next cycle. Codes 110 and 111 are ignored. An init request during recovery cancels it, clears `run_cnt_o` and leaves `busoff_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_strobe_i | input | 1 | One-cycle pulse at each bit sample point |
| rx_bit_i | input | 1 | Received bus bit, 1 = recessive |
| tx_bit_i | input | 1 | Transmit bit from the protocol engine |
| busoff_enter_i | input | 1 | Bus-off entry pulse from the protocol engine |
| mode_req_valid_i | input | 1 | Mode change request strobe |
| mode_req_i | input | 3 | Requested mode code |
| tx_o | output | 1 | Transmit bit to the bus |
| busoff_o | output | 1 | Bus-off flag |
| mode_o | output | 3 | Current mode code |
| run_cnt_o | output | 7 | Completed recessive runs in the current recovery |

## Verification
The hardest state to reach from the ports is the edge of completion. Here `run_cnt_o` has reached 127, and the current run is one recessive bit short of the grant. The stimulus drives exactly 127 runs of 11 recessive bits, then 10 more, and shows that nothing is granted. Only the single further bit that follows releases the bus. The wake path needs a particular bit history as well. The bench first samples a recessive bit and then a dominant one while in sleep with bus-off set, so that the edge is seen at a strobe with no host request in the same cycle.

// File: rtl/can_bor_pkg.sv
package can_bor_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_INIT     = 3'b000,
    MODE_NORMAL   = 3'b001,
    MODE_LISTEN   = 3'b010,
    MODE_SELFTEST = 3'b011,
    MODE_SLEEP    = 3'b100,
    MODE_STOP     = 3'b101
  } mode_e;

  function automatic logic is_op(input logic [MODE_W-1:0] m);
    return (m == MODE_NORMAL) || (m == MODE_LISTEN) || (m == MODE_SELFTEST);
  endfunction
endpackage

// File: rtl/can_bor_runcnt.sv
module can_bor_runcnt #(
  parameter int RUN_LEN    = 11,
  parameter int RUN_TARGET = 128,
  localparam int BIT_W     = $clog2(RUN_LEN + 1),
  localparam int CNT_W     = $clog2(RUN_TARGET)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             clear_i,
  input  logic             strobe_i,
  input  logic             rx_i,
  output logic [CNT_W-1:0] run_cnt_o,
  output logic             done_o
);
  logic [BIT_W-1:0] bit_q;
  logic [CNT_W-1:0] run_q;
  logic             run_end;

  assign run_end   = strobe_i & active_i & rx_i & (bit_q == BIT_W'(RUN_LEN - 1));
  assign done_o    = run_end & (run_q == CNT_W'(RUN_TARGET - 1));
  assign run_cnt_o = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= '0;
    end else if (clear_i || !active_i) begin
      bit_q <= '0;
    end else if (strobe_i) begin
      if (!rx_i || run_end) bit_q <= '0;
      else                  bit_q <= bit_q + BIT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
    end else if (clear_i || done_o) begin
      run_q <= '0;
    end else if (run_end) begin
      run_q <= run_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/can_bor_wake.sv
module can_bor_wake (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic rx_i,
  output logic edge_o
);
  logic last_q;

  assign edge_o = strobe_i & last_q & ~rx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       last_q <= 1'b1;
    else if (strobe_i) last_q <= rx_i;
  end
endmodule

// File: rtl/can_bor_mode_fsm.sv
module can_bor_mode_fsm
  import can_bor_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [MODE_W-1:0] req_i,
  input  logic              busoff_enter_i,
  input  logic              wake_i,
  input  logic              done_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              busoff_o,
  output logic              recovering_o,
  output logic              restart_o
);
  logic [MODE_W-1:0] mode_q, mode_d, pend_q, pend_d, last_q, last_d;
  logic              busoff_q, busoff_d, rec_q, rec_d;

  always_comb begin
    mode_d    = mode_q;
    pend_d    = pend_q;
    last_d    = last_q;
    busoff_d  = busoff_q;
    rec_d     = rec_q;
    restart_o = 1'b0;
    if (busoff_enter_i && is_op(mode_q)) busoff_d = 1'b1;
    if (rec_q && done_i) begin
      mode_d   = pend_q;
      busoff_d = 1'b0;
      rec_d    = 1'b0;
    end else if (req_valid_i) begin
      case (mode_q)
        MODE_INIT: begin
          if (is_op(req_i)) begin
            last_d = req_i;
            if (busoff_q) begin
              pend_d    = req_i;
              rec_d     = 1'b1;
              restart_o = 1'b1;
            end else begin
              mode_d = req_i;
            end
          end else if (req_i == MODE_SLEEP) begin
            mode_d = MODE_SLEEP;
            rec_d  = 1'b0;
          end else if (req_i == MODE_INIT) begin
            rec_d     = 1'b0;
            restart_o = 1'b1;
          end
        end
        MODE_NORMAL, MODE_LISTEN, MODE_SELFTEST: begin
          if (req_i == MODE_INIT) begin
            mode_d = MODE_INIT;
          end else if (is_op(req_i)) begin
            mode_d = req_i;
            last_d = req_i;
          end else if (req_i == MODE_SLEEP) begin
            mode_d = MODE_SLEEP;
          end
        end
        MODE_SLEEP: begin
          if (is_op(req_i)) begin
            last_d = req_i;
            if (busoff_q) begin
              mode_d    = MODE_INIT;
              pend_d    = req_i;
              rec_d     = 1'b1;
              restart_o = 1'b1;
            end else begin
              mode_d = req_i;
            end
          end else if (req_i == MODE_STOP) begin
            mode_d = MODE_STOP;
          end
        end
        MODE_STOP: begin
          if (req_i == MODE_SLEEP) mode_d = MODE_SLEEP;
        end
        default: mode_d = MODE_INIT;
      endcase
    end else if (mode_q == MODE_SLEEP && wake_i) begin
      if (busoff_q) begin
        mode_d    = MODE_INIT;
        pend_d    = last_q;
        rec_d     = 1'b1;
        restart_o = 1'b1;
      end else begin
        mode_d = last_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_INIT;
      pend_q   <= MODE_NORMAL;
      last_q   <= MODE_NORMAL;
      busoff_q <= 1'b0;
      rec_q    <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      pend_q   <= pend_d;
      last_q   <= last_d;
      busoff_q <= busoff_d;
      rec_q    <= rec_d;
    end
  end

  assign mode_o       = mode_q;
  assign busoff_o     = busoff_q;
  assign recovering_o = rec_q;
endmodule

// File: rtl/can_busoff_ctrl.sv
module can_busoff_ctrl
  import can_bor_pkg::*;
#(
  parameter int  RUN_LEN    = 11,
  parameter int  RUN_TARGET = 128,
  localparam int CNT_W      = $clog2(RUN_TARGET)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_strobe_i,
  input  logic              rx_bit_i,
  input  logic              tx_bit_i,
  input  logic              busoff_enter_i,
  input  logic              mode_req_valid_i,
  input  logic [MODE_W-1:0] mode_req_i,
  output logic              tx_o,
  output logic              busoff_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [CNT_W-1:0]  run_cnt_o
);
  logic wake, done, recovering, restart;

  can_bor_wake u_wake (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (bit_strobe_i),
    .rx_i     (rx_bit_i),
    .edge_o   (wake)
  );

  can_bor_runcnt #(
    .RUN_LEN    (RUN_LEN),
    .RUN_TARGET (RUN_TARGET)
  ) u_runcnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (recovering),
    .clear_i   (restart),
    .strobe_i  (bit_strobe_i),
    .rx_i      (rx_bit_i),
    .run_cnt_o (run_cnt_o),
    .done_o    (done)
  );

  can_bor_mode_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (mode_req_valid_i),
    .req_i          (mode_req_i),
    .busoff_enter_i (busoff_enter_i),
    .wake_i         (wake),
    .done_i         (done),
    .mode_o         (mode_o),
    .busoff_o       (busoff_o),
    .recovering_o   (recovering),
    .restart_o      (restart)
  );

  // recessive unless actively operating on the bus
  assign tx_o = (busoff_o || !is_op(mode_o)) ? 1'b1 : tx_bit_i;
endmodule

// File: rtl/can_bor_checks.sv
module can_bor_checks
  import can_bor_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busoff_enter_i,
  input logic              mode_req_valid_i,
  input logic [MODE_W-1:0] mode_req_i,
  input logic              tx_o,
  input logic              busoff_o,
  input logic [MODE_W-1:0] mode_o,
  input logic [CNT_W-1:0]  run_cnt_o
);
  AST_TX_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busoff_o |-> tx_o); // R1

  AST_MODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o inside {MODE_INIT, MODE_NORMAL, MODE_LISTEN, MODE_SELFTEST, MODE_SLEEP, MODE_STOP}); // R2

  AST_BUSOFF_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busoff_enter_i && is_op(mode_o)) |=> busoff_o); // R2

  AST_INIT_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_req_valid_i && mode_req_i == MODE_INIT && is_op(mode_o)) |=> mode_o == MODE_INIT); // R3

  AST_RUN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_cnt_o != $past(run_cnt_o)) |->
      (run_cnt_o == $past(run_cnt_o) + CNT_W'(1) || run_cnt_o == '0)); // R5

  AST_EXIT_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busoff_o) |-> (run_cnt_o == '0 && is_op(mode_o))); // R6

  AST_SLEEP_NO_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_SLEEP && mode_req_valid_i && mode_req_i == MODE_INIT) |=> mode_o == MODE_SLEEP); // R9
endmodule

bind can_busoff_ctrl can_bor_checks #(.CNT_W(CNT_W)) u_checks (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .busoff_enter_i   (busoff_enter_i),
  .mode_req_valid_i (mode_req_valid_i),
  .mode_req_i       (mode_req_i),
  .tx_o             (tx_o),
  .busoff_o         (busoff_o),
  .mode_o           (mode_o),
  .run_cnt_o        (run_cnt_o)
);

// File: tb/tb_can_busoff_ctrl.sv
`timescale 1ns/1ps
module tb_can_busoff_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe = 1'b0, rx = 1'b1, tx_bit = 1'b1, enter = 1'b0, req_v = 1'b0;
  logic [2:0] req = 3'd0;
  logic       tx_o, busoff_o;
  logic [2:0] mode_o;
  logic [6:0] cnt_o;

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  can_busoff_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_strobe_i(strobe), .rx_bit_i(rx),
    .tx_bit_i(tx_bit), .busoff_enter_i(enter), .mode_req_valid_i(req_v),
    .mode_req_i(req), .tx_o(tx_o), .busoff_o(busoff_o), .mode_o(mode_o),
    .run_cnt_o(cnt_o)
  );

  // behavioural reference model
  int m_mode, m_busoff, m_cnt, m_bits, m_rec, m_pend, m_last, m_prev;

  function automatic bit opm(int x);
    return x >= 1 && x <= 3;
  endfunction

  task automatic m_start(int target);
    m_pend = target; m_rec = 1; m_cnt = 0; m_bits = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_busoff = 0; m_cnt = 0; m_bits = 0;
      m_rec = 0; m_pend = 1; m_last = 1; m_prev = 1;
    end else begin
      int  om, ob;
      bit  orec, fin, wk;
      om = m_mode; ob = m_busoff; orec = m_rec[0]; fin = 0;
      wk = strobe && m_prev == 1 && rx == 1'b0;
      if (orec && strobe) begin
        if (!rx) m_bits = 0;
        else begin
          m_bits++;
          if (m_bits == 11) begin
            m_bits = 0; m_cnt++;
            if (m_cnt == 128) fin = 1;
          end
        end
      end
      if (enter && opm(om)) m_busoff = 1;
      if (fin) begin
        m_mode = m_pend; m_busoff = 0; m_rec = 0; m_cnt = 0; m_bits = 0;
      end else if (req_v) begin
        int r;
        r = int'(req);
        if (om == 0) begin
          if (opm(r)) begin
            m_last = r;
            if (ob != 0) m_start(r); else m_mode = r;
          end else if (r == 4) begin m_mode = 4; m_rec = 0; end
          else if (r == 0) begin m_rec = 0; m_cnt = 0; end
        end else if (opm(om)) begin
          if (r == 0) m_mode = 0;
          else if (opm(r)) begin m_mode = r; m_last = r; end
          else if (r == 4) m_mode = 4;
        end else if (om == 4) begin
          if (opm(r)) begin
            m_last = r;
            if (ob != 0) begin m_mode = 0; m_start(r); end else m_mode = r;
          end else if (r == 5) m_mode = 5;
        end else if (om == 5) begin
          if (r == 4) m_mode = 4;
        end
      end else if (om == 4 && wk) begin
        if (ob != 0) begin m_mode = 0; m_start(m_last); end else m_mode = m_last;
      end
      if (m_rec == 0) m_bits = 0;
      if (strobe) m_prev = int'(rx);
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // per-cycle comparison, between edges
  always @(posedge clk) begin
    cycles++;
    #1;
    if (rst_n && !finished) begin
      chk("R1 tx_o vs model", int'(tx_o), (m_busoff != 0 || !opm(m_mode)) ? 1 : int'(tx_bit));
      chk("R8 busoff_o vs model", int'(busoff_o), m_busoff);
      chk("R3 mode_o vs model", int'(mode_o), m_mode);
      chk("R5 run_cnt_o vs model", int'(cnt_o), m_cnt);
    end
  end

  task automatic summary();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 60000 && !finished) begin
      errors++;
      $display("FAIL watchdog R6 actual=%0d cycles expected=done", cycles);
      summary();
    end
  end

  task automatic request(logic [2:0] code);
    req = code; req_v = 1'b1;
    @(negedge clk);
    req_v = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_enter();
    enter = 1'b1;
    @(negedge clk);
    enter = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_bits(logic val, int n);
    for (int i = 0; i < n; i++) begin
      rx = val; strobe = 1'b1;
      @(negedge clk);
      strobe = 1'b0;
      @(negedge clk);
    end
    rx = 1'b1;
  endtask

  task automatic send_runs(int n);
    send_bits(1'b1, n * 11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset tx", int'(tx_o), 1);
    chk("R2 reset mode", int'(mode_o), 0);
    chk("R8 reset busoff", int'(busoff_o), 0);
    chk("R5 reset count", int'(cnt_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    request(3'b001);
    chk("R12 direct op entry", int'(mode_o), 1);
    tx_bit = 1'b0;
    @(negedge clk);
    chk("R1 tx follows engine", int'(tx_o), 0);

    pulse_enter();
    chk("R2 busoff set", int'(busoff_o), 1);
    chk("R1 tx held recessive", int'(tx_o), 1);

    request(3'b110);
    chk("R12 invalid code ignored", int'(mode_o), 1);

    request(3'b000);
    chk("R3 init ack", int'(mode_o), 0);
    chk("R8 busoff kept in init", int'(busoff_o), 1);

    request(3'b001);
    chk("R4 op request pending", int'(mode_o), 0);
    chk("R4 count cleared", int'(cnt_o), 0);

    send_bits(1'b1, 10);
    send_bits(1'b0, 1);
    send_bits(1'b1, 11);
    chk("R5 dominant restarts run", int'(cnt_o), 1);
    send_runs(2);
    chk("R5 back-to-back runs", int'(cnt_o), 3);

    request(3'b010);
    chk("R7 re-request clears count", int'(cnt_o), 0);
    chk("R7 still init", int'(mode_o), 0);

    send_runs(127);
    chk("R5 count at 127", int'(cnt_o), 127);
    send_bits(1'b1, 10);
    chk("R8 busoff before last bit", int'(busoff_o), 1);
    chk("R4 still pending", int'(mode_o), 0);
    send_bits(1'b1, 1);
    chk("R6 pending mode entered", int'(mode_o), 2);
    chk("R6 busoff cleared", int'(busoff_o), 0);
    chk("R6 count cleared", int'(cnt_o), 0);
    chk("R1 tx released", int'(tx_o), 0);

    pulse_enter();
    request(3'b100);
    chk("R9 sleep while busoff", int'(mode_o), 4);
    request(3'b000);
    chk("R9 init rejected in sleep", int'(mode_o), 4);
    request(3'b101);
    chk("R9 stop from sleep", int'(mode_o), 5);
    request(3'b000);
    chk("R9 init rejected in stop", int'(mode_o), 5);
    request(3'b100);
    chk("R9 stop back to sleep", int'(mode_o), 4);
    request(3'b001);
    chk("R10 sleep release to init", int'(mode_o), 0);
    chk("R8 busoff through release", int'(busoff_o), 1);
    send_runs(128);
    chk("R10 recovery after release", int'(mode_o), 1);
    chk("R6 busoff cleared again", int'(busoff_o), 0);

    pulse_enter();
    request(3'b100);
    send_bits(1'b1, 1);
    chk("R11 no wake on recessive", int'(mode_o), 4);
    send_bits(1'b0, 1);
    chk("R11 wake starts recovery", int'(mode_o), 0);
    send_runs(1);
    chk("R11 runs counted after wake", int'(cnt_o), 1);
    request(3'b000);
    chk("R12 init cancel clears count", int'(cnt_o), 0);
    chk("R12 busoff kept on cancel", int'(busoff_o), 1);
    send_runs(1);
    chk("R12 no counting after cancel", int'(cnt_o), 0);
    request(3'b011);
    send_runs(128);
    chk("R6 self-test entered", int'(mode_o), 3);

    request(3'b100);
    send_bits(1'b1, 1);
    send_bits(1'b0, 1);
    chk("R11 wake without busoff", int'(mode_o), 3);
    chk("R2 busoff stays clear", int'(busoff_o), 0);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule